// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer

The block holds three independent 16-bit down-counters behind a byte-wide register interface. Each channel has its own data port. A fourth port takes write-only command bytes. Each channel counts on the shared count enable `tick_i`, one step per enabled clock. It drives a single output whose waveform depends on the programmed operating mode. The modes that run are terminal-count interrupt, rate generation and square wave.

A command byte either reprograms one channel or asks it to freeze its current count for a later read. A reprogram sets the channel's byte access order and operating mode. Reload values arrive as one or two byte writes. Reads return the live count, or the frozen snapshot, in the same byte order. Port addresses 0, 1 and 2 reach channels 0, 1 and 2. Address 3 is the command port and reads back as zero.

Top module: `pit_timer`

## Requirements
- R1: A command byte carries the channel in bits 7:6, the access order in bits 5:4 and the mode in bits 3:1. Bit 0 (BCD select) is ignored and counting is always binary. A select value of 3 leaves every channel's count, output and settings unchanged.
- R2: After reset, or after a reprogramming command, the addressed channel's output is high and its counter is stopped. A reprogramming command also restarts both byte-order trackers at the low byte and drops any held snapshot.
- R3: The access order sets how data writes build the reload value. Code 01 writes the low byte with the high byte zero. Code 10 writes the high byte with the low byte zero. Code 11 writes the low byte and then the high byte. With code 11 nothing is loaded until the high byte arrives, so the count and output are unchanged after the low byte alone.
- R4: A data read returns a byte selected by the access order. Code 01 gives the low byte and code 10 the high byte. Code 11 gives the low byte on one read and the high byte on the next, alternating.
- R5: An access code of 00 in a command freezes that channel's count in a snapshot. Reads return the snapshot until every byte of it has been read, and then return the live count again. A second freeze command while a snapshot is still held has no effect.
- R6: The counter changes only on clocks where `tick_i` is high.
- R7: In mode 0 the output goes low when a complete reload value N is written. It goes high on the Nth enabled tick and stays high until the channel is reprogrammed or reloaded. The counter keeps decrementing and wraps through 0xFFFF.
- R8: In mode 2 the output is high and drops low for exactly one tick period each time the count reaches 1. The reload then restarts the count, so the period is N ticks.
- R9: In mode 3 the output is high for ceil(N/2) ticks and low for floor(N/2) ticks, with N of at least 2.
- R10: Mode codes 6 and 7 behave exactly like codes 2 and 3.
- R11: A reload value of 0 counts as 65536 ticks.
- R12: Mode codes 1, 4 and 5 are accepted and decoded only. The output stays high and the loaded count does not change with ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count enable shared by all channels |
| wr_i | input | 1 | Write strobe for the addressed port |
| rd_i | input | 1 | Read strobe; advances read byte order and snapshot release |
| addr_i | input | 2 | Port select: 0 to 2 are channel data, 3 is command |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the addressed port, valid while rd_i is high |
| out_o | output | 3 | Channel output waveforms, bit n for channel n |

## Verification
The bench measures full high and low run lengths on each output. It compares them against N-1/1 for rate mode and ceil/floor halves for square mode, including an odd reload, a divided count enable and the 6/7 aliases. A design that miscounted by one would produce periods of N±1. A design that ignored the alias would leave the output flat.

The bench interleaves a freeze command with ticks between the two byte reads. This catches a snapshot released too early or overwritten by a second freeze command. It also writes only the low byte in two-byte order and confirms that the count reads unchanged, which exposes an early load. A 65536-tick terminal count confirms that a zero reload means the full range rather than an immediate or single-tick expiry.

// File: rtl/pit_pkg.sv
`timescale 1ns/1ps
package pit_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;

  typedef enum logic [2:0] {
    MODE_TC        = 3'd0,
    MODE_ONESHOT   = 3'd1,
    MODE_RATE      = 3'd2,
    MODE_SQUARE    = 3'd3,
    MODE_SW_STROBE = 3'd4,
    MODE_HW_STROBE = 3'd5
  } pit_mode_e;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'd0,
    ACC_LO    = 2'd1,
    ACC_HI    = 2'd2,
    ACC_LOHI  = 2'd3
  } pit_acc_e;

  // codes 6/7 fold onto 2/3
  function automatic pit_mode_e fold_mode(logic [2:0] code);
    if (code[2:1] == 2'b11) return pit_mode_e'({1'b0, code[1:0]});
    return pit_mode_e'(code);
  endfunction

  function automatic logic mode_runs(pit_mode_e m);
    return (m == MODE_TC) || (m == MODE_RATE) || (m == MODE_SQUARE);
  endfunction
endpackage

// File: rtl/pit_count_core.sv
`timescale 1ns/1ps
module pit_count_core
  import pit_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             prog_i,
  input  logic             load_i,
  input  pit_mode_e        mode_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] count_o,
  output logic             out_o
);
  logic             run_q, out_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   n_ext;
  logic [CNT_W-1:0] hi_half, lo_half;
  logic             start;

  // zero reload stands for 2^CNT_W
  assign n_ext   = {reload_i == '0, reload_i};
  assign hi_half = CNT_W'((n_ext + (CNT_W+1)'(1)) >> 1);
  assign lo_half = n_ext[CNT_W:1];

  // running rate/square channels pick up a new value at their next reload
  assign start = load_i && (mode_i == MODE_TC || !mode_runs(mode_i) || !run_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      out_q <= 1'b1;
      cnt_q <= '0;
    end else if (prog_i) begin
      run_q <= 1'b0;
      out_q <= 1'b1;
    end else if (start) begin
      case (mode_i)
        MODE_TC:     begin cnt_q <= reload_i; out_q <= 1'b0; run_q <= 1'b1; end
        MODE_RATE:   begin cnt_q <= reload_i; out_q <= 1'b1; run_q <= 1'b1; end
        MODE_SQUARE: begin cnt_q <= hi_half;  out_q <= 1'b1; run_q <= 1'b1; end
        default:     begin cnt_q <= reload_i; out_q <= 1'b1; run_q <= 1'b0; end
      endcase
    end else if (run_q && tick_i) begin
      case (mode_i)
        MODE_TC: begin
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q == CNT_W'(1)) out_q <= 1'b1;
        end
        MODE_RATE: begin
          if (cnt_q == CNT_W'(1)) begin
            cnt_q <= reload_i;
            out_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CNT_W'(2)) out_q <= 1'b0;
          end
        end
        MODE_SQUARE: begin
          if (cnt_q == CNT_W'(1)) begin
            out_q <= ~out_q;
            cnt_q <= out_q ? lo_half : hi_half;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign count_o = cnt_q;
  assign out_o   = out_q;

  AST_PROG_OUT_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_i |=> out_o); // R2
  AST_CNT_HOLD_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_i && !prog_i) |=> $stable(count_o)); // R6
  AST_TC_HOLD_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_TC && out_o && !load_i) |=> out_o); // R7
  AST_RATE_LOW_ONE_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && mode_i == MODE_RATE && !out_o && tick_i) |=> out_o); // R8
  AST_UNSUP_OUT_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_runs(mode_i) |-> out_o); // R12
endmodule

// File: rtl/pit_channel.sv
`timescale 1ns/1ps
module pit_channel
  import pit_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              cmd_wr_i,
  input  logic [1:0]        cmd_acc_i,
  input  logic [2:0]        cmd_mode_i,
  input  logic              data_wr_i,
  input  logic              data_rd_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              out_o
);
  localparam int PAD_W = CNT_W - BYTE_W;

  pit_mode_e         mode_q;
  pit_acc_e          acc_q;
  logic              wr_hi_q, rd_hi_q, latched_q;
  logic [BYTE_W-1:0] lo_hold_q;
  logic [CNT_W-1:0]  reload_q, reload_d, latch_q, count, src;
  logic              cmd_latch, cmd_prog, load, sel_hi;

  assign cmd_latch = cmd_wr_i && (pit_acc_e'(cmd_acc_i) == ACC_LATCH);
  assign cmd_prog  = cmd_wr_i && !cmd_latch;
  assign load      = data_wr_i && (acc_q != ACC_LOHI || wr_hi_q);

  always_comb begin
    reload_d = reload_q;
    if (load) begin
      case (acc_q)
        ACC_LO:  reload_d = {{PAD_W{1'b0}}, wdata_i};
        ACC_HI:  reload_d = {wdata_i, {PAD_W{1'b0}}};
        default: reload_d = {wdata_i, lo_hold_q};
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= MODE_TC;
      acc_q     <= ACC_LOHI;
      wr_hi_q   <= 1'b0;
      rd_hi_q   <= 1'b0;
      latched_q <= 1'b0;
      lo_hold_q <= '0;
      reload_q  <= '0;
      latch_q   <= '0;
    end else if (cmd_prog) begin
      mode_q    <= fold_mode(cmd_mode_i);
      acc_q     <= pit_acc_e'(cmd_acc_i);
      wr_hi_q   <= 1'b0;
      rd_hi_q   <= 1'b0;
      latched_q <= 1'b0;
    end else if (cmd_latch) begin
      if (!latched_q) begin
        latched_q <= 1'b1;
        latch_q   <= count;
      end
    end else begin
      if (data_wr_i && acc_q == ACC_LOHI) begin
        if (!wr_hi_q) lo_hold_q <= wdata_i;
        wr_hi_q <= ~wr_hi_q;
      end
      reload_q <= reload_d;
      if (data_rd_i) begin
        if (acc_q == ACC_LOHI) rd_hi_q <= ~rd_hi_q;
        if (latched_q && (acc_q != ACC_LOHI || rd_hi_q)) latched_q <= 1'b0;
      end
    end
  end

  pit_count_core u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .prog_i   (cmd_prog),
    .load_i   (load),
    .mode_i   (mode_q),
    .reload_i (reload_d),
    .count_o  (count),
    .out_o    (out_o)
  );

  assign src     = latched_q ? latch_q : count;
  assign sel_hi  = (acc_q == ACC_HI) || (acc_q == ACC_LOHI && rd_hi_q);
  assign rdata_o = sel_hi ? src[CNT_W-1 -: BYTE_W] : src[BYTE_W-1:0];

  AST_SNAPSHOT_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latched_q && !data_rd_i && !cmd_prog) |=> $stable(rdata_o)); // R5
endmodule

// File: rtl/pit_timer.sv
`timescale 1ns/1ps
module pit_timer
  import pit_pkg::*;
#(
  parameter  int N_CH   = 3,
  localparam int ADDR_W = $clog2(N_CH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic [N_CH-1:0]   out_o
);
  localparam logic [ADDR_W-1:0] CMD_ADDR = ADDR_W'(N_CH);

  logic [BYTE_W-1:0] ch_rdata [N_CH];
  logic              cmd_wr;

  assign cmd_wr = wr_i && (addr_i == CMD_ADDR);

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    pit_channel u_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .tick_i     (tick_i),
      .cmd_wr_i   (cmd_wr && (wdata_i[7:6] == 2'(c))),
      .cmd_acc_i  (wdata_i[5:4]),
      .cmd_mode_i (wdata_i[3:1]),
      .data_wr_i  (wr_i && (addr_i == ADDR_W'(c))),
      .data_rd_i  (rd_i && (addr_i == ADDR_W'(c))),
      .wdata_i    (wdata_i),
      .rdata_o    (ch_rdata[c]),
      .out_o      (out_o[c])
    );
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < N_CH; i++) begin
      if (addr_i == ADDR_W'(i)) rdata_o = ch_rdata[i];
    end
  end
endmodule

// File: tb/pit_timer_tb_top.sv
`timescale 1ns/1ps
module pit_timer_tb_top;
  typedef struct {
    int    ch;
    int    hi;
    int    lo;
    string req;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i;
  logic       wr_i = 1'b0;
  logic       rd_i = 1'b0;
  logic [1:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic [2:0] out_o;

  int checks = 0, fails = 0;
  int mon_checks = 0, mon_fails = 0;
  int burst_req = 0, burst_done = 0, tick_div = 0;
  int watch_ch = 0, watch_id = 0, mon_idx = 0;
  bit watch_en = 1'b0;
  exp_t exp_q[$];
  logic [7:0] b;

  initial forever #4 clk = ~clk;

  pit_timer #(.N_CH(3)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .wr_i(wr_i), .rd_i(rd_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .out_o(out_o)
  );

  // tick source: exact bursts or a free-running divider
  initial begin
    int ph = 0;
    tick_i = 1'b0;
    forever begin
      @(negedge clk);
      if (burst_done < burst_req) begin
        tick_i = 1'b1;
        burst_done++;
      end else if (tick_div != 0) begin
        tick_i = (ph == 0);
        ph = (ph + 1 >= tick_div) ? 0 : ph + 1;
      end else begin
        tick_i = 1'b0;
      end
    end
  end

  // monitor: measures complete high/low runs and pops expected periods
  initial begin
    int last_id = -1;
    int run_len = 0, hi_len = 0;
    logic cur = 1'b0, lvl;
    bit have_edge = 0, hi_ok = 0;
    forever begin
      @(negedge clk);
      #2;
      if (watch_en) begin
        lvl = out_o[watch_ch];
        if (last_id != watch_id) begin
          last_id = watch_id; cur = lvl; run_len = 1; have_edge = 0; hi_ok = 0;
        end else if (lvl == cur) begin
          run_len++;
        end else begin
          if (cur) begin
            hi_ok = have_edge;
            hi_len = run_len;
          end else if (have_edge && hi_ok && mon_idx < exp_q.size()) begin
            mon_checks++;
            if (hi_len != exp_q[mon_idx].hi || run_len != exp_q[mon_idx].lo) begin
              mon_fails++;
              $display("FAIL %s ch%0d period: actual hi=%0d lo=%0d expected hi=%0d lo=%0d",
                       exp_q[mon_idx].req, watch_ch, hi_len, run_len,
                       exp_q[mon_idx].hi, exp_q[mon_idx].lo);
            end
            mon_idx++;
          end
          have_edge = 1; cur = lvl; run_len = 1;
        end
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    $display("FAIL watchdog expired: actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks + mon_checks + 1, fails + mon_fails + 1);
    $finish;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk);
    wr_i = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr_i = a; rd_i = 1'b1;
    #1 d = rdata_o;
    @(negedge clk);
    rd_i = 1'b0;
  endtask

  task automatic ticks(int n);
    burst_req += n;
    wait (burst_done == burst_req);
    @(posedge clk);
    #1;
  endtask

  task automatic period(int ch, logic [7:0] cmd, int nb, logic [7:0] b0, logic [7:0] b1,
                        int div, int reps, int hi, int lo, string req);
    int t = 0;
    wr(2'd3, cmd);
    wr(2'(ch), b0);
    if (nb == 2) wr(2'(ch), b1);
    watch_ch = ch; watch_id++; watch_en = 1'b1;
    for (int i = 0; i < reps; i++) exp_q.push_back('{ch, hi, lo, req});
    tick_div = div;
    while (mon_idx < exp_q.size() && t < 20000) begin
      @(negedge clk);
      t++;
    end
    chk({req, " periods seen"}, mon_idx, exp_q.size());
    tick_div = 0; watch_en = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R2 reset outputs high", out_o, 3'b111);

    // ch0, mode 0, low/high order
    wr(2'd3, 8'h30);
    chk("R2 output high after command", out_o[0], 1'b1);
    wr(2'd0, 8'h34);
    chk("R3 low byte alone does not load", out_o[0], 1'b1);
    wr(2'd0, 8'h12);
    chk("R7 output low on load", out_o[0], 1'b0);
    rd(2'd0, b); chk("R4 read low byte", b, 8'h34);
    rd(2'd0, b); chk("R4 read high byte", b, 8'h12);
    ticks(10);
    rd(2'd0, b); chk("R6 count after 10 ticks lo", b, 8'h2A);
    rd(2'd0, b); chk("R6 count after 10 ticks hi", b, 8'h12);

    // freeze and partial read
    wr(2'd3, 8'h00);
    ticks(5);
    rd(2'd0, b); chk("R5 snapshot low", b, 8'h2A);
    ticks(3);
    rd(2'd0, b); chk("R5 snapshot high", b, 8'h12);
    rd(2'd0, b); chk("R5 live after release lo", b, 8'h22);
    rd(2'd0, b); chk("R5 live after release hi", b, 8'h12);
    wr(2'd3, 8'h00);
    ticks(2);
    wr(2'd3, 8'h00);
    rd(2'd0, b); chk("R5 second freeze ignored lo", b, 8'h22);
    rd(2'd0, b); chk("R5 second freeze ignored hi", b, 8'h12);
    rd(2'd0, b); chk("R5 live lo", b, 8'h20);
    rd(2'd0, b); chk("R5 live hi", b, 8'h12);

    // partial low/high write
    wr(2'd0, 8'h55);
    rd(2'd0, b); chk("R3 count kept after low byte lo", b, 8'h20);
    rd(2'd0, b); chk("R3 count kept after low byte hi", b, 8'h12);
    wr(2'd0, 8'h00);
    rd(2'd0, b); chk("R3 new value lo", b, 8'h55);
    rd(2'd0, b); chk("R3 new value hi", b, 8'h00);

    // select 3 ignored
    wr(2'd3, 8'hF4);
    chk("R1 select 3 leaves outputs", out_o, 3'b110);
    rd(2'd0, b); chk("R1 select 3 leaves count lo", b, 8'h55);
    rd(2'd0, b); chk("R1 select 3 leaves count hi", b, 8'h00);

    // terminal count
    wr(2'd3, 8'h30);
    chk("R2 reprogram raises output", out_o[0], 1'b1);
    wr(2'd0, 8'h05); wr(2'd0, 8'h00);
    ticks(4);
    chk("R7 low before terminal", out_o[0], 1'b0);
    ticks(1);
    chk("R7 high at terminal", out_o[0], 1'b1);
    ticks(7);
    chk("R7 stays high", out_o[0], 1'b1);
    rd(2'd0, b); chk("R7 wrapped count lo", b, 8'hF9);
    rd(2'd0, b); chk("R7 wrapped count hi", b, 8'hFF);

    // zero reload
    wr(2'd3, 8'h30);
    wr(2'd0, 8'h00); wr(2'd0, 8'h00);
    ticks(65535);
    chk("R11 low after 65535 ticks", out_o[0], 1'b0);
    ticks(1);
    chk("R11 high after 65536 ticks", out_o[0], 1'b1);

    // periodic modes
    period(1, 8'h74, 2, 8'd5, 8'd0, 1, 3, 4, 1, "R8 rate N=5");
    period(1, 8'h7C, 2, 8'd5, 8'd0, 1, 3, 4, 1, "R10 code 6 as rate");
    period(2, 8'hB6, 2, 8'd6, 8'd0, 1, 3, 3, 3, "R9 square N=6");
    period(2, 8'hBE, 2, 8'd7, 8'd0, 1, 3, 4, 3, "R10 code 7 as square odd R9");
    period(1, 8'h54, 1, 8'd8, 8'd0, 1, 2, 7, 1, "R3 low-only rate N=8");
    period(2, 8'hA4, 1, 8'd1, 8'd0, 1, 2, 255, 1, "R3 high-only rate N=256");
    period(1, 8'h74, 2, 8'd4, 8'd0, 3, 3, 9, 3, "R6 rate N=4 tick every 3");

    // decode-only modes
    wr(2'd3, 8'h98);
    wr(2'd2, 8'h03);
    ticks(10);
    chk("R12 mode 4 output high", out_o[2], 1'b1);
    rd(2'd2, b); chk("R12 mode 4 count frozen", b, 8'h03);
    wr(2'd3, 8'h92);
    wr(2'd2, 8'h09);
    ticks(4);
    chk("R12 mode 1 output high", out_o[2], 1'b1);
    rd(2'd2, b); chk("R12 mode 1 count frozen", b, 8'h09);
    rd(2'd3, b); chk("R4 command port reads zero", b, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks + mon_checks, fails + mon_fails);
    $finish;
  end
endmodule